// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting channel of an interval timer. A register interface hands it an initial count, a mode number and a BCD/binary choice with a single load strobe. The counter then advances only on cycles where the count-clock enable is high, under control of a gate input. It drives a single output line whose waveform depends on the selected mode. The live counter value is brought out so that a separate latch can sample it.

Six modes share one counter. Two of them are periodic and reload the initial count at terminal count. The other four let the counter wrap through its maximum value and keep going. The square-wave mode steps by two per count. Two of the modes wait for a gate rising edge before they start. An initial count of zero stands for the largest count of the selected number system.

In the requirements, N is the initial count and d is the number of counted enable cycles since the channel last started or restarted. The start cycle itself has d = 0. An "enable cycle" is a clock with the count enable high and no load strobe.

Top module: `interval_counter`

## Requirements
- R1: After reset, outLine is low and countVal is 0.
- R2: A load strobe captures loadVal, modeSel and bcdSel. On the next clock, outLine takes the mode's idle level: high for modes 1 and 3, low for modes 0, 2, 4 and 5. In modes 0, 2, 3 and 4, the counter takes N on the next enable cycle, and that cycle is d = 0.
- R3: A loaded value of 0 acts as N = 65536 in binary and N = 10000 in BCD. countVal then shows 0 at each reload.
- R4: In mode 0, outLine goes high when d = N and stays high. The counter wraps from 0 to 0xFFFF (binary) and keeps counting down, so countVal = (N − d) mod 65536.
- R5: In mode 1, nothing starts until a gate rising edge. The edge loads N and drives outLine low until d = N, after which outLine is high. A later rising edge restarts the count.
- R6: In mode 2, the counter reloads N when d is a multiple of N. outLine is high for the one count period after each reload and low otherwise, including at d = 0.
- R7: In mode 3, the counter steps by two. outLine is high while (d mod N) < ceil(N/2) and low otherwise. With N = 1, outLine stays high.
- R8: In mode 4 (start on load) and mode 5 (start on gate rising edge), outLine is high for exactly the one count period where d = N. It does not pulse again when the counter wraps.
- R9: In modes 0, 2, 3 and 4, an enable cycle with gate low changes neither countVal nor outLine. In modes 1 and 5, the gate level does not affect counting.
- R10: In modes 2 and 3, a gate rising edge on a started channel restarts from N with d = 0. outLine becomes low in mode 2 and high in mode 3.
- R11: With bcdSel = 1, countVal holds four BCD digits, with digit i at bits 4i+3:4i. Each digit counts down within 0 to 9 and borrows from the next digit. 0000 wraps to 9999.
- R12: Mode codes 6 and 7 behave exactly like modes 2 and 3.
- R13: A gate rising edge seen on a cycle without the enable is held and acted on at the next enable cycle. A load strobe discards a held edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Count-clock enable, one count per high cycle |
| gate | input | 1 | Gate level; rising edges trigger or restart |
| loadStb | input | 1 | Load strobe for count, mode and number system |
| loadVal | input | 16 | Initial count (binary or packed BCD) |
| modeSel | input | 3 | Operating mode 0 to 7 |
| bcdSel | input | 1 | 1 selects BCD counting, 0 binary |
| outLine | output | 1 | Channel output waveform |
| countVal | output | 16 | Live counter value |

## Verification
Each mode is run with small odd and even counts and with a count of one. These cases separate off-by-one terminal detection from the correct position of the pulse or duty-cycle edge. Wrap runs in binary and BCD, including a zero load in each, show whether the counter wraps or reloads and whether the maximum count is honoured. Gate patterns cover a low level during counting, a rising edge during counting, and a brief pulse falling between sparse enable cycles. Together they separate suspension from restart and show whether an edge that misses an enable is kept. The aliased mode codes are run against their base modes.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef enum logic [2:0] {
    M_TERM_INT  = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } cmode_e;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic loadInit;
    logic loadLow;
    logic step1;
    logic step2;
  } dpCmd_t;

  // Status from datapath to control.
  typedef struct packed {
    logic cntIsOne;
    logic cntIsTwo;
    logic cntOdd;
    logic initIsOne;
  } dpFlag_t;

endpackage

// File: rtl/interval_counter_dp.sv
module interval_counter_dp
  import ictr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loadStb,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             bcdSel,
  input  dpCmd_t           cmd,
  output dpFlag_t          flags,
  output logic [WIDTH-1:0] countVal
);

  localparam int NDIG = WIDTH / 4;

  logic [WIDTH-1:0] initQ;
  logic [WIDTH-1:0] cntQ;
  logic             bcdQ;
  logic [1:0]       amt;
  logic [WIDTH-1:0] decBin;
  logic [WIDTH-1:0] decBcd;
  logic [WIDTH-1:0] decVal;
  logic [WIDTH-1:0] lowVal;
  logic [NDIG:1]    bcdBorrow;

  assign amt    = cmd.step2 ? 2'd2 : 2'd1;
  assign decBin = cntQ - WIDTH'(amt);

  // Decimal subtract chain, one stage per digit.
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [3:0] digIn;
    logic [3:0] subIn;
    logic [4:0] diff;
    assign digIn = cntQ[4*g +: 4];
    if (g == 0) begin : g_lsd
      assign subIn = {2'b00, amt};
    end else begin : g_upper
      assign subIn = {3'b000, bcdBorrow[g]};
    end
    assign bcdBorrow[g+1] = (digIn < subIn);
    assign diff = bcdBorrow[g+1] ? ({1'b0, digIn} + 5'd10 - {1'b0, subIn})
                                 : ({1'b0, digIn} - {1'b0, subIn});
    assign decBcd[4*g +: 4] = diff[3:0];
  end

  assign decVal = bcdQ ? decBcd : decBin;
  // An odd count minus one is the same bit pattern in either radix.
  assign lowVal = {initQ[WIDTH-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      initQ <= '0;
      bcdQ  <= 1'b0;
      cntQ  <= '0;
    end else begin
      if (loadStb) begin
        initQ <= loadVal;
        bcdQ  <= bcdSel;
      end
      if (cmd.loadInit)                cntQ <= initQ;
      else if (cmd.loadLow)            cntQ <= lowVal;
      else if (cmd.step1 || cmd.step2) cntQ <= decVal;
    end
  end

  assign flags.cntIsOne  = (cntQ == WIDTH'(1));
  assign flags.cntIsTwo  = (cntQ == WIDTH'(2));
  assign flags.cntOdd    = cntQ[0];
  assign flags.initIsOne = (initQ == WIDTH'(1));
  assign countVal        = cntQ;

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.loadInit, cmd.loadLow, cmd.step1, cmd.step2})); // R2
  AST_BIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.step1 && !bcdQ && (cntQ == '0) |=> (cntQ == '1)); // R4
  AST_BCD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.step1 && bcdQ && bcdBorrow[NDIG] |=> (cntQ == {NDIG{4'h9}})); // R11
  AST_STEP2_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.step2 |-> !cntQ[0]); // R7

endmodule

// File: rtl/interval_counter_ctrl.sv
module interval_counter_ctrl
  import ictr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loadStb,
  input  logic [2:0] modeIn,
  input  logic       cntEn,
  input  logic       gate,
  input  dpFlag_t    flags,
  output dpCmd_t     cmd,
  output logic       outLine
);

  cmode_e modeQ;
  logic   loadPend, armed, running, fired, phaseHigh, outQ;
  logic   gatePrev, risePend;
  logic   isM15, isM23, tick, trig, startLoad, trigStart, counting, hiTerm;
  logic [2:0] modeMapped;

  // Codes 6 and 7 alias the two periodic modes.
  assign modeMapped = (modeIn[2:1] == 2'b11) ? {1'b0, modeIn[1:0]} : modeIn;

  always_comb begin
    isM15     = (modeQ == M_ONESHOT) || (modeQ == M_HW_STROBE);
    isM23     = (modeQ == M_RATE) || (modeQ == M_SQUARE);
    tick      = cntEn && !loadStb;
    trig      = risePend || (gate && !gatePrev);
    startLoad = tick && loadPend;
    trigStart = tick && !loadPend && trig &&
                ((isM15 && armed) || (isM23 && running));
    counting  = tick && !loadPend && !trigStart && running && (gate || isM15);
    hiTerm    = flags.cntIsOne || flags.cntIsTwo;
    cmd       = '0;
    if (startLoad || trigStart) begin
      cmd.loadInit = 1'b1;
    end else if (counting) begin
      case (modeQ)
        M_RATE: begin
          if (flags.cntIsOne) cmd.loadInit = 1'b1;
          else                cmd.step1    = 1'b1;
        end
        M_SQUARE: begin
          if (phaseHigh) begin
            if (hiTerm) begin
              if (flags.initIsOne) cmd.loadInit = 1'b1;
              else                 cmd.loadLow  = 1'b1;
            end else if (flags.cntOdd) begin
              cmd.step1 = 1'b1;
            end else begin
              cmd.step2 = 1'b1;
            end
          end else begin
            if (flags.cntIsTwo) cmd.loadInit = 1'b1;
            else                cmd.step2    = 1'b1;
          end
        end
        default: cmd.step1 = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ     <= M_TERM_INT;
      loadPend  <= 1'b0;
      armed     <= 1'b0;
      running   <= 1'b0;
      fired     <= 1'b0;
      phaseHigh <= 1'b0;
      outQ      <= 1'b0;
      gatePrev  <= 1'b0;
      risePend  <= 1'b0;
    end else begin
      gatePrev <= gate;
      if (loadStb) begin
        modeQ    <= cmode_e'(modeMapped);
        loadPend <= !((modeMapped == 3'd1) || (modeMapped == 3'd5));
        armed    <= 1'b1;
        running  <= 1'b0;
        risePend <= 1'b0;
        outQ     <= (modeMapped == 3'd1) || (modeMapped == 3'd3);
      end else if (cntEn) begin
        risePend <= 1'b0;
        if (startLoad) begin
          loadPend  <= 1'b0;
          running   <= 1'b1;
          fired     <= 1'b0;
          phaseHigh <= 1'b1;
        end else if (trigStart) begin
          running   <= 1'b1;
          fired     <= 1'b0;
          phaseHigh <= 1'b1;
          outQ      <= (modeQ == M_SQUARE);
        end else if (counting) begin
          case (modeQ)
            M_TERM_INT, M_ONESHOT: begin
              if (!fired && flags.cntIsOne) begin
                fired <= 1'b1;
                outQ  <= 1'b1;
              end
            end
            M_SW_STROBE, M_HW_STROBE: begin
              if (!fired && flags.cntIsOne) begin
                fired <= 1'b1;
                outQ  <= 1'b1;
              end else begin
                outQ <= 1'b0;
              end
            end
            M_RATE: outQ <= flags.cntIsOne;
            M_SQUARE: begin
              if (phaseHigh) begin
                if (hiTerm && !flags.initIsOne) begin
                  phaseHigh <= 1'b0;
                  outQ      <= 1'b0;
                end
              end else if (flags.cntIsTwo) begin
                phaseHigh <= 1'b1;
                outQ      <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end else if (gate && !gatePrev) begin
        risePend <= 1'b1;
      end
    end
  end

  assign outLine = outQ;

  AST_ONESHOT_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    loadStb && (modeIn == 3'd1) |=> outLine); // R2
  AST_TERMINT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    loadStb && (modeIn == 3'd0) |=> !outLine); // R2
  AST_TERMINT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == M_TERM_INT) && outQ && !loadStb |=> outQ); // R4
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !gate && ((modeQ == M_TERM_INT) || (modeQ == M_SW_STROBE))
    |=> $stable(outQ)); // R9

endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import ictr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEn,
  input  logic             gate,
  input  logic             loadStb,
  input  logic [WIDTH-1:0] loadVal,
  input  logic [2:0]       modeSel,
  input  logic             bcdSel,
  output logic             outLine,
  output logic [WIDTH-1:0] countVal
);

  dpCmd_t  cmd;
  dpFlag_t flags;

  interval_counter_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .loadStb (loadStb),
    .modeIn  (modeSel),
    .cntEn   (cntEn),
    .gate    (gate),
    .flags   (flags),
    .cmd     (cmd),
    .outLine (outLine)
  );

  interval_counter_dp #(.WIDTH(WIDTH)) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .loadStb  (loadStb),
    .loadVal  (loadVal),
    .bcdSel   (bcdSel),
    .cmd      (cmd),
    .flags    (flags),
    .countVal (countVal)
  );

endmodule

// File: tb/test_interval_counter.sv
`timescale 1ns/1ps
module test_interval_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cntEn = 1'b0;
  logic        gate = 1'b0;
  logic        loadStb = 1'b0;
  logic [15:0] loadVal = '0;
  logic [2:0]  modeSel = '0;
  logic        bcdSel = 1'b0;
  logic        outLine;
  logic [15:0] countVal;

  interval_counter i_interval_counter (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .gate(gate), .loadStb(loadStb),
    .loadVal(loadVal), .modeSel(modeSel), .bcdSel(bcdSel),
    .outLine(outLine), .countVal(countVal)
  );

  always #2 clk = ~clk;

  int    errs = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 0;

  // Behavioural reference: elapsed-count formulas per mode.
  int mN, mMode, mD, expCnt;
  bit mBcd, mStarted, mArmed, mPend, mRp, mGp, expOut, rise, trig, m15;

  function automatic int bcdToInt(input logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  function automatic int toBcd(input int v);
    return ((v/1000)%10)*4096 + ((v/100)%10)*256 + ((v/10)%10)*16 + (v%10);
  endfunction

  task automatic refCompute();
    int modv, v;
    modv = mBcd ? 10000 : 65536;
    v = -1;
    case (mMode)
      0, 1: begin expOut = (mD >= mN); v = ((mN - mD) % modv + modv) % modv; end
      2: begin
        expOut = ((mD % mN) == 0) && (mD != 0);
        v = mN - (mD % mN);
        if (v == modv) v = 0;
      end
      3: begin expOut = (mD % mN) < ((mN + 1) / 2); v = -1; end
      default: begin expOut = (mD == mN); v = ((mN - mD) % modv + modv) % modv; end
    endcase
    expCnt = (v < 0) ? -1 : (mBcd ? toBcd(v) : v);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mN = 1; mMode = 0; mD = 0; expCnt = 0; mBcd = 0; mStarted = 0;
      mArmed = 0; mPend = 0; mRp = 0; mGp = 0; expOut = 0;
    end else begin
      rise = gate && !mGp;
      mGp  = gate;
      if (loadStb) begin
        mBcd  = bcdSel;
        mMode = (modeSel >= 3'd6) ? int'(modeSel) - 4 : int'(modeSel);
        if (loadVal == 16'h0) mN = bcdSel ? 10000 : 65536;
        else mN = bcdSel ? bcdToInt(loadVal) : int'(loadVal);
        mStarted = 0; mArmed = 1; mRp = 0;
        mPend  = !(mMode == 1 || mMode == 5);
        expOut = (mMode == 1 || mMode == 3);
      end else if (cntEn) begin
        trig = mRp || rise;
        mRp  = 0;
        m15  = (mMode == 1 || mMode == 5);
        if (mPend) begin mPend = 0; mStarted = 1; mD = 0; end
        else if (m15 && trig && mArmed) begin mStarted = 1; mD = 0; end
        else if ((mMode == 2 || mMode == 3) && trig && mStarted) mD = 0;
        else if (mStarted && (gate || m15)) mD++;
        if (mStarted) refCompute();
      end else if (rise) begin
        mRp = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (outLine !== expOut) begin
        errs++;
        $display("FAIL %s outLine: actual=%0b expected=%0b (t=%0t)", tag, outLine, expOut, $time);
      end
      if (expCnt >= 0) begin
        checks++;
        if (countVal !== 16'(expCnt)) begin
          errs++;
          $display("FAIL %s countVal: actual=%h expected=%h (t=%0t)", tag, countVal, 16'(expCnt), $time);
        end
      end
    end
  end

  task automatic doLoad(input logic [15:0] v, input logic [2:0] m, input logic b);
    @(negedge clk);
    loadStb = 1; loadVal = v; modeSel = m; bcdSel = b; cntEn = 0;
    @(negedge clk);
    loadStb = 0;
  endtask

  task automatic ticks(input int n, input int stride);
    for (int i = 0; i < n; i++) begin
      for (int k = 1; k < stride; k++) begin
        @(negedge clk); cntEn = 0;
      end
      @(negedge clk); cntEn = 1;
    end
  endtask

  task automatic setGate(input logic g);
    @(negedge clk); cntEn = 0; gate = g;
  endtask

  task automatic gateTick(input logic g);
    @(negedge clk); cntEn = 1; gate = g;
  endtask

  initial begin
    gate = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; // reset state
    checks++;
    if (outLine !== 1'b0 || countVal !== 16'h0) begin
      errs++;
      $display("FAIL R1 reset: actual=%0b/%h expected=0/0000", outLine, countVal);
    end

    tag = "R2"; doLoad(16'd5, 3'd0, 0); setGate(1); ticks(2, 1);
    tag = "R4"; ticks(20, 1);
    tag = "R9"; doLoad(16'd10, 3'd0, 0); ticks(3, 1);
    gateTick(0); ticks(4, 1); gateTick(1); ticks(12, 1);
    tag = "R9"; doLoad(16'd6, 3'd4, 0); ticks(3, 1); gateTick(0); ticks(3, 1);
    gateTick(1); ticks(8, 1);

    tag = "R5"; doLoad(16'd4, 3'd1, 0); setGate(0); ticks(3, 1);
    gateTick(1); ticks(3, 1); setGate(0); gateTick(1); ticks(8, 1);
    setGate(0); ticks(3, 1); // R9: gate level ignored in one-shot
    setGate(1); ticks(2, 1);

    tag = "R6"; doLoad(16'd3, 3'd2, 0); ticks(14, 1);
    doLoad(16'd1, 3'd2, 0); ticks(5, 1);
    tag = "R10"; doLoad(16'd7, 3'd2, 0); ticks(4, 1); gateTick(0); ticks(2, 1);
    gateTick(1); ticks(10, 1);

    tag = "R7"; doLoad(16'd5, 3'd3, 0); ticks(22, 1);
    doLoad(16'd6, 3'd3, 0); ticks(20, 1);
    doLoad(16'd1, 3'd3, 0); ticks(5, 1);
    doLoad(16'd2, 3'd3, 0); ticks(6, 1);
    doLoad(16'h0015, 3'd3, 1); ticks(30, 1);
    tag = "R10"; doLoad(16'd9, 3'd3, 0); ticks(6, 1); gateTick(0); ticks(2, 1);
    gateTick(1); ticks(12, 1);

    tag = "R8"; doLoad(16'd3, 3'd4, 0); ticks(10, 1);
    doLoad(16'd3, 3'd5, 0); setGate(0); ticks(2, 1); gateTick(1); ticks(3, 1);
    setGate(0); ticks(6, 1); // R9: low gate does not stop strobe mode 5

    tag = "R11"; doLoad(16'h0012, 3'd0, 1); setGate(1); ticks(30, 1);
    doLoad(16'h0010, 3'd2, 1); ticks(25, 1);
    doLoad(16'h1000, 3'd4, 1); ticks(5, 1);

    tag = "R12"; doLoad(16'd4, 3'd6, 0); ticks(12, 1);
    doLoad(16'd3, 3'd7, 0); ticks(12, 1);

    tag = "R13"; doLoad(16'd3, 3'd1, 0); setGate(0); ticks(2, 3);
    setGate(1); setGate(0); ticks(6, 3);
    doLoad(16'd4, 3'd2, 0); ticks(2, 1); setGate(1); setGate(0); setGate(1);
    ticks(6, 3);

    tag = "R3"; doLoad(16'h0000, 3'd2, 1); ticks(10010, 1);
    doLoad(16'h0000, 3'd0, 0); ticks(65540, 1);

    @(negedge clk); cntEn = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL %s watchdog: actual=running expected=finished", tag);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule